// File: doc/BRIEF.md
# Trap Return Unwinder

This block executes the two return-from-trap operations of a processor's privileged architecture: the machine-level return and the supervisor-level return. Each request names the return level, the privilege the hart currently runs at, the current interrupt-enable and previous-privilege status fields, both saved exception PCs and whether compressed instructions are supported.

One clock after a request the block reports one of two results. It either gives the PC to resume at, the privilege to resume in and the rewritten status fields, or it gives an exception with its cause code. On success the enable bit of the returning level is reloaded from its saved copy. The saved copy is then cleared, and the saved previous privilege is reset to user. The rewritten status then passes the same legalization that any status write would see, so that a previous-privilege field never holds a mode the hart lacks.

Top module: `trap_return_unit`

## Requirements
- R1: While reset is asserted and after it, before any request, `done` and `fault` are 0, `out_priv` is 3 (machine), `ret_pc` is 0 and all status outputs are 0.
- R2: A request with `req_is_mach`=1 at `cur_priv` below 3, or with `req_is_mach`=0 at `cur_priv` below 1, completes with `fault`=1 and `fault_cause`=2 (illegal instruction). This check takes priority over R3.
- R3: With `rvc_en`=0, a permitted return whose selected exception PC (`mepc` for machine, `sepc` for supervisor) has bits 1:0 not equal to 0 completes with `fault`=1 and `fault_cause`=0 (misaligned fetch address). With `rvc_en`=1 no alignment fault is raised.
- R4: A successful machine return gives `out_mie`=`st_mpie`, `out_mpie`=0, `out_mpp`=0 (user), `out_priv`=old `st_mpp` and `ret_pc`=`mepc`.
- R5: A successful supervisor return gives `out_sie`=`st_spie`, `out_spie`=0, `out_spp`=0, `out_priv`={0,old `st_spp`} and `ret_pc`=`sepc`.
- R6: When a machine return would restore the reserved privilege 2, `out_priv` is 0 (user).
- R7: When a request faults, `out_priv` equals `cur_priv`, the status outputs equal the status inputs, and `ret_pc` keeps its previous value.
- R8: `done` is 1 for exactly the clock after each request cycle and 0 after every cycle without a request. Back-to-back requests give back-to-back results.
- R9: A machine return copies the supervisor fields (`st_sie`, `st_spie`, `st_spp`) through unchanged. A supervisor return copies the machine fields (`st_mie`, `st_mpie`, `st_mpp`) through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Return request this cycle |
| req_is_mach | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Saved machine interrupt enable |
| st_mpp | input | 2 | Saved machine previous privilege |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Saved supervisor interrupt enable |
| st_spp | input | 1 | Saved supervisor previous privilege |
| mepc | input | XLEN | Machine exception PC |
| sepc | input | XLEN | Supervisor exception PC |
| rvc_en | input | 1 | Compressed instructions supported |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Request raised an exception |
| fault_cause | output | 4 | Exception cause code |
| ret_pc | output | XLEN | PC to resume at |
| out_priv | output | 2 | Privilege after the return |
| out_mie | output | 1 | Resulting machine interrupt enable |
| out_mpie | output | 1 | Resulting saved machine interrupt enable |
| out_mpp | output | 2 | Resulting machine previous privilege |
| out_sie | output | 1 | Resulting supervisor interrupt enable |
| out_spie | output | 1 | Resulting saved supervisor interrupt enable |
| out_spp | output | 1 | Resulting supervisor previous privilege |

## Verification
The bench targets three corner cases. The first is a request that is both under-privileged and misaligned: a design that checks in the wrong order reports cause 0 instead of 2. The second is a machine return with a saved previous privilege of 2: a design without the remap resumes in the reserved mode. The third is a misaligned PC with compressed support on: an overly eager check faults a legal return. Returns that fault are also compared field by field against the inputs, since a design that commits the unwind before the check would clear saved enables it should have kept. Back-to-back and idle cycles expose a `done` that stretches or goes missing.

// File: rtl/trap_return_pkg.sv
package trap_return_pkg;

    typedef enum logic [1:0] {
        PRIV_U    = 2'd0,
        PRIV_S    = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_M    = 2'd3
    } priv_e;

    typedef struct packed {
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
        logic       sie;
        logic       spie;
        logic       spp;
    } status_t;

    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH_MISALIGN = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL_INSN   = 4'd2;

endpackage

// File: rtl/trap_return_check.sv
module trap_return_check
    import trap_return_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               is_mach,
    input  priv_e              cur_priv,
    input  logic [XLEN-1:0]    mepc,
    input  logic [XLEN-1:0]    sepc,
    input  logic               rvc_en,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    target_pc
);
    localparam int ALIGN_BITS = 2;

    priv_e needed;
    logic  priv_low;
    logic  misaligned;

    always_comb begin
        needed     = is_mach ? PRIV_M : PRIV_S;
        target_pc  = is_mach ? mepc : sepc;
        priv_low   = (cur_priv < needed);
        misaligned = !rvc_en && (target_pc[ALIGN_BITS-1:0] != '0);
        fault      = priv_low || misaligned;
        // privilege violation is reported ahead of alignment
        cause      = priv_low ? CAUSE_ILLEGAL_INSN : CAUSE_FETCH_MISALIGN;
    end

endmodule

// File: rtl/trap_return_unwind.sv
module trap_return_unwind
    import trap_return_pkg::*;
(
    input  logic    is_mach,
    input  status_t st_in,
    output status_t st_raw,
    output priv_e   priv_next
);
    logic [1:0] restored;

    always_comb begin
        st_raw = st_in;
        if (is_mach) begin
            restored    = st_in.mpp;
            st_raw.mie  = st_in.mpie;
            st_raw.mpie = 1'b0;
            st_raw.mpp  = PRIV_U;
        end else begin
            restored    = {1'b0, st_in.spp};
            st_raw.sie  = st_in.spie;
            st_raw.spie = 1'b0;
            st_raw.spp  = 1'b0;
        end
        // reserved level falls back to user
        priv_next = (restored == PRIV_RSVD) ? PRIV_U : priv_e'(restored);
    end

endmodule

// File: rtl/trap_return_legalize.sv
module trap_return_legalize
    import trap_return_pkg::*;
#(
    parameter bit SUPPORT_U = 1'b1,
    parameter bit SUPPORT_S = 1'b1
) (
    input  status_t old_st,
    input  status_t new_st,
    output status_t legal_st
);
    logic mpp_bad;
    logic spp_keep;

    generate
        if (SUPPORT_S) begin : g_with_s
            assign spp_keep = 1'b0;
        end else begin : g_without_s
            assign spp_keep = 1'b1;
        end
    endgenerate

    always_comb begin
        mpp_bad = (new_st.mpp == PRIV_RSVD)
               || (!SUPPORT_U && new_st.mpp == PRIV_U)
               || (!SUPPORT_S && new_st.mpp == PRIV_S);
        legal_st = new_st;
        if (mpp_bad) legal_st.mpp = old_st.mpp;
        if (spp_keep) legal_st.spp = old_st.spp;
    end

endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
    import trap_return_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter bit SUPPORT_U = 1'b1,
    parameter bit SUPPORT_S = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_is_mach,
    input  logic [1:0]      cur_priv,
    input  logic            st_mie,
    input  logic            st_mpie,
    input  logic [1:0]      st_mpp,
    input  logic            st_sie,
    input  logic            st_spie,
    input  logic            st_spp,
    input  logic [XLEN-1:0] mepc,
    input  logic [XLEN-1:0] sepc,
    input  logic            rvc_en,
    output logic            done,
    output logic            fault,
    output logic [3:0]      fault_cause,
    output logic [XLEN-1:0] ret_pc,
    output logic [1:0]      out_priv,
    output logic            out_mie,
    output logic            out_mpie,
    output logic [1:0]      out_mpp,
    output logic            out_sie,
    output logic            out_spie,
    output logic            out_spp
);
    typedef struct packed {
        logic               done;
        logic               fault;
        logic [CAUSE_W-1:0] cause;
        logic [XLEN-1:0]    pc;
        priv_e              priv;
        status_t            st;
    } result_t;

    status_t            st_in;
    status_t            st_raw;
    status_t            st_legal;
    priv_e              priv_in;
    priv_e              priv_next;
    logic               chk_fault;
    logic [CAUSE_W-1:0] chk_cause;
    logic [XLEN-1:0]    chk_pc;
    result_t            res_d, res_q;

    always_comb begin
        st_in   = '{mie: st_mie, mpie: st_mpie, mpp: st_mpp,
                    sie: st_sie, spie: st_spie, spp: st_spp};
        priv_in = priv_e'(cur_priv);
    end

    trap_return_check #(.XLEN(XLEN)) u_check (
        .is_mach  (req_is_mach),
        .cur_priv (priv_in),
        .mepc     (mepc),
        .sepc     (sepc),
        .rvc_en   (rvc_en),
        .fault    (chk_fault),
        .cause    (chk_cause),
        .target_pc(chk_pc)
    );

    trap_return_unwind u_unwind (
        .is_mach  (req_is_mach),
        .st_in    (st_in),
        .st_raw   (st_raw),
        .priv_next(priv_next)
    );

    trap_return_legalize #(.SUPPORT_U(SUPPORT_U), .SUPPORT_S(SUPPORT_S)) u_legal (
        .old_st  (st_in),
        .new_st  (st_raw),
        .legal_st(st_legal)
    );

    always_comb begin
        res_d       = res_q;
        res_d.done  = req_valid;
        res_d.fault = 1'b0;
        if (req_valid) begin
            if (chk_fault) begin
                res_d.fault = 1'b1;
                res_d.cause = chk_cause;
                res_d.priv  = priv_in;
                res_d.st    = st_in;
            end else begin
                res_d.pc    = chk_pc;
                res_d.priv  = priv_next;
                res_d.st    = st_legal;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q      <= '0;
            res_q.priv <= PRIV_M;
        end else begin
            res_q <= res_d;
        end
    end

    always_comb begin
        done        = res_q.done;
        fault       = res_q.fault;
        fault_cause = res_q.cause;
        ret_pc      = res_q.pc;
        out_priv    = res_q.priv;
        out_mie     = res_q.st.mie;
        out_mpie    = res_q.st.mpie;
        out_mpp     = res_q.st.mpp;
        out_sie     = res_q.st.sie;
        out_spie    = res_q.st.spie;
        out_spp     = res_q.st.spp;
    end

endmodule

// File: rtl/trap_return_unit_chk.sv
module trap_return_unit_chk #(
    parameter int XLEN      = 32,
    parameter bit SUPPORT_U = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_is_mach,
    input logic [1:0]      cur_priv,
    input logic            st_mpie,
    input logic [XLEN-1:0] mepc,
    input logic [XLEN-1:0] sepc,
    input logic            rvc_en,
    input logic            done,
    input logic            fault,
    input logic [3:0]      fault_cause,
    input logic [1:0]      out_priv,
    input logic            out_mie,
    input logic            out_mpie,
    input logic [1:0]      out_mpp
);
    p_done_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);

    p_no_spurious_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);

    p_low_priv_illegal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ((req_is_mach && cur_priv != 2'd3) || (!req_is_mach && cur_priv == 2'd0)))
        |=> (fault && fault_cause == 4'd2));

    p_misalign_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rvc_en && ((req_is_mach && cur_priv == 2'd3 && mepc[1:0] != 2'b00)
            || (!req_is_mach && cur_priv != 2'd0 && sepc[1:0] != 2'b00)))
        |=> (fault && fault_cause == 4'd0));

    p_mret_unwind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_mach && cur_priv == 2'd3 && (rvc_en || mepc[1:0] == 2'b00))
        |=> (!fault && out_mie == $past(st_mpie) && !out_mpie && (!SUPPORT_U || out_mpp == 2'd0)));

    p_no_reserved_priv_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> out_priv != 2'd2);

    p_fault_keeps_priv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_mach && cur_priv != 2'd3) |=> out_priv == $past(cur_priv));

endmodule

bind trap_return_unit trap_return_unit_chk #(.XLEN(XLEN), .SUPPORT_U(SUPPORT_U)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_is_mach(req_is_mach),
    .cur_priv   (cur_priv),
    .st_mpie    (st_mpie),
    .mepc       (mepc),
    .sepc       (sepc),
    .rvc_en     (rvc_en),
    .done       (done),
    .fault      (fault),
    .fault_cause(fault_cause),
    .out_priv   (out_priv),
    .out_mie    (out_mie),
    .out_mpie   (out_mpie),
    .out_mpp    (out_mpp)
);

// File: tb/trap_return_unit_bench.sv
module trap_return_unit_bench;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_is_mach = 1'b0;
    logic [1:0] cur_priv = 2'd0;
    logic st_mie = 0, st_mpie = 0, st_sie = 0, st_spie = 0, st_spp = 0;
    logic [1:0] st_mpp = 2'd0;
    logic [XLEN-1:0] mepc = '0, sepc = '0;
    logic rvc_en = 1'b0;
    logic done, fault, out_mie, out_mpie, out_sie, out_spie, out_spp;
    logic [3:0] fault_cause;
    logic [XLEN-1:0] ret_pc;
    logic [1:0] out_priv, out_mpp;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference state, one cycle ahead of the ports
    logic e_done = 0, e_fault = 0, e_mie = 0, e_mpie = 0, e_sie = 0, e_spie = 0, e_spp = 0;
    logic [3:0] e_cause = 0;
    logic [XLEN-1:0] e_pc = 0;
    logic [1:0] e_priv = 2'd3, e_mpp = 0;

    always #4 clk = ~clk;

    trap_return_unit #(.XLEN(XLEN)) u_trap_return_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_mach(req_is_mach),
        .cur_priv(cur_priv), .st_mie(st_mie), .st_mpie(st_mpie), .st_mpp(st_mpp),
        .st_sie(st_sie), .st_spie(st_spie), .st_spp(st_spp), .mepc(mepc), .sepc(sepc),
        .rvc_en(rvc_en), .done(done), .fault(fault), .fault_cause(fault_cause),
        .ret_pc(ret_pc), .out_priv(out_priv), .out_mie(out_mie), .out_mpie(out_mpie),
        .out_mpp(out_mpp), .out_sie(out_sie), .out_spie(out_spie), .out_spp(out_spp)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "done", 64'(done), 64'(e_done));
        chk(tag, "fault", 64'(fault), 64'(e_fault));
        if (e_fault) chk(tag, "cause", 64'(fault_cause), 64'(e_cause));
        chk(tag, "ret_pc", 64'(ret_pc), 64'(e_pc));
        chk(tag, "priv", 64'(out_priv), 64'(e_priv));
        chk(tag, "mstat", 64'({out_mie, out_mpie, out_mpp}), 64'({e_mie, e_mpie, e_mpp}));
        chk(tag, "sstat", 64'({out_sie, out_spie, out_spp}), 64'({e_sie, e_spie, e_spp}));
    endtask

    // behavioural model of one clock edge, from the requirements
    task automatic model_edge();
        logic [XLEN-1:0] pc;
        int need;
        e_done  = req_valid;
        e_fault = 1'b0;
        if (req_valid) begin
            need = req_is_mach ? 3 : 1;
            pc   = req_is_mach ? mepc : sepc;
            if (int'(cur_priv) < need) begin
                e_fault = 1; e_cause = 4'd2;
            end else if (!rvc_en && pc[1:0] != 2'b00) begin
                e_fault = 1; e_cause = 4'd0;
            end
            if (e_fault) begin
                e_priv = cur_priv;
                {e_mie, e_mpie, e_mpp, e_sie, e_spie, e_spp} =
                    {st_mie, st_mpie, st_mpp, st_sie, st_spie, st_spp};
            end else begin
                e_pc = pc;
                {e_mie, e_mpie, e_mpp, e_sie, e_spie, e_spp} =
                    {st_mie, st_mpie, st_mpp, st_sie, st_spie, st_spp};
                if (req_is_mach) begin
                    e_priv = (st_mpp == 2'd2) ? 2'd0 : st_mpp;
                    e_mie = st_mpie; e_mpie = 0; e_mpp = 2'd0;
                end else begin
                    e_priv = {1'b0, st_spp};
                    e_sie = st_spie; e_spie = 0; e_spp = 0;
                end
            end
        end
    endtask

    // apply one cycle of stimulus at a negedge and compare at the next negedge
    task automatic cycle(input logic v, input logic m, input logic [1:0] p,
                         input logic [6:0] st, input logic [XLEN-1:0] me,
                         input logic [XLEN-1:0] se, input logic c, input string tag);
        req_valid = v; req_is_mach = m; cur_priv = p;
        {st_mie, st_mpie, st_mpp, st_sie, st_spie, st_spp} = st;
        mepc = me; sepc = se; rvc_en = c;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic idle(input string tag);
        cycle(1'b0, 1'b0, 2'd0, 7'b0, '0, '0, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        compare_all("R1 after reset");
        // status word = {mie, mpie, mpp[1:0], sie, spie, spp}
        cycle(1, 1, 2'd3, 7'b0_1_01_0_1_1, 32'h0000_1000, 32'h0000_2004, 0, "R4 R9 mret to S");
        idle("R8 idle after request");
        cycle(1, 1, 2'd3, 7'b1_0_11_1_0_0, 32'h0000_1100, 32'h0, 0, "R4 mret to M");
        cycle(1, 1, 2'd3, 7'b0_1_10_1_1_1, 32'h0000_1200, 32'h0, 0, "R6 reserved mpp");
        cycle(1, 0, 2'd1, 7'b1_1_11_0_1_1, 32'h0, 32'h0000_3000, 0, "R5 R9 sret to S");
        cycle(1, 0, 2'd3, 7'b0_0_01_1_0_0, 32'h0, 32'h0000_3100, 0, "R5 sret from M to U");
        idle("R8 idle");
        cycle(1, 0, 2'd0, 7'b1_1_11_0_1_1, 32'h0, 32'h0000_4000, 0, "R2 R7 sret from U");
        cycle(1, 1, 2'd1, 7'b0_1_01_1_1_1, 32'h0000_4100, 32'h0, 0, "R2 R7 mret from S");
        cycle(1, 1, 2'd0, 7'b0_1_11_0_0_0, 32'h0000_4200, 32'h0, 1, "R2 mret from U");
        cycle(1, 1, 2'd3, 7'b0_1_01_0_0_0, 32'h0000_5002, 32'h0, 0, "R3 R7 mret misaligned");
        cycle(1, 0, 2'd1, 7'b0_0_00_0_1_1, 32'h0, 32'h0000_5003, 0, "R3 sret misaligned");
        cycle(1, 1, 2'd3, 7'b0_1_01_0_0_0, 32'h0000_5006, 32'h0, 1, "R3 compressed allowed");
        cycle(1, 0, 2'd0, 7'b0_0_00_0_1_1, 32'h0, 32'h0000_5001, 0, "R2 R3 priority");
        idle("R8 idle");
        cycle(1, 0, 2'd1, 7'b0_0_00_1_0_1, 32'h0, 32'h0000_6000, 0, "R5 spie 0");
        for (int i = 0; i < 16; i++) begin
            cycle(1, i[0], 2'(i % 4 == 2 ? 3 : i % 4), 7'(i * 37 + 5),
                  32'(32'h8000 + i * 2), 32'(32'h9000 + i * 3), i[2], "R8 R9 sweep");
        end
        idle("R8 final idle");
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule